// File: doc/BRIEF.md
# UART Register File with Byte FIFOs

This block is the processor-facing side of a small serial port. Software reaches it through a 32-bit register port. A write strobe, a read strobe and a word index select one of seven registers. Behind the port sit an 8-entry transmit queue and an 8-entry receive queue of bytes. There are also two watermark control words, an interrupt enable word, a computed interrupt pending word and a stored divisor word. On the line side, the oldest transmit byte is offered with a valid/ready handshake. Incoming bytes are accepted through a second valid/ready handshake. A single level-sensitive interrupt line reports the enabled conditions.

The serial shifter, framing and baud generation sit outside this block. The divisor is only kept here for them and read back. Read data is registered: it appears on `reg_rdata` in the cycle after the read strobe and holds until the next read. A read of the receive register removes the byte it returns.

Word index map: 0 transmit data, 1 receive data, 2 transmit control, 3 receive control, 4 interrupt enable, 5 interrupt pending, 6 divisor. Index 7 reads as zero. Software sees these as byte offsets of four times the index.

Top module: `uart_regfile`

## Requirements
- R1: After reset, every register reads as zero, both queues are empty, `tx_valid` and `irq` are low and `rx_ready` is high. The receive register then reads 0x80000000.
- R2: A write to index 0 queues bits 7:0 of the written word. The line side receives the queued bytes in write order on `tx_data` while `tx_valid` is high. One byte is removed on each cycle with `tx_valid` and `tx_ready` both high.
- R3: A write to index 0 while 8 bytes are queued is dropped. Reading index 0 returns bit 31 set exactly when the transmit queue holds 8 bytes, with all other bits zero. The bit clears after one byte drains.
- R4: A read of index 1 while the receive queue is non-empty returns the oldest byte in bits 7:0, with bits 31:8 zero, and removes that byte.
- R5: A read of index 1 while the receive queue is empty returns 0x80000000 and changes nothing.
- R6: `rx_ready` is low exactly when the receive queue holds 8 bytes. A byte offered then is discarded, and the queue contents stay unchanged.
- R7: Bit 0 of the pending word (index 5) is 1 exactly when bits 18:16 of the transmit control word are nonzero.
- R8: Bit 1 of the pending word is 1 exactly when the receive queue level is strictly greater than bits 18:16 of the receive control word. All other pending bits read 0.
- R9: `irq` is high when enable bit 0 is set. It is also high when enable bit 1 is set and the receive queue holds at least one byte. Otherwise it is low.
- R10: Indices 2, 3, 4 and 6 store and read back all 32 written bits. Writes to index 5 and index 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| tx_data | output | 8 | Oldest queued transmit byte |
| tx_valid | output | 1 | Transmit queue non-empty |
| tx_ready | input | 1 | Line side takes the offered byte |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Receive queue has room |
| irq | output | 1 | Level interrupt |

## Verification
A wrong queue pointer or level shows up on the ports at once. The line side then presents a byte out of order, `rx_ready` drops at the wrong fill level, or the receive register yields the empty word one read early or late. Pending and interrupt faults appear combinationally: `irq` reacts in the cycle after the enable write, and the pending word can be seen by the next read. This makes it possible to sweep every watermark setting against every receive level and compare the results with a simple arithmetic rule. A stale transmit full flag can be seen by reading index 0 right after the queue fills or drains by one.

// File: rtl/uart_regfile_pkg.sv
`timescale 1ns/1ps
package uart_regfile_pkg;

  localparam int WORD_W  = 32;
  localparam int IDX_W   = 3;
  localparam int BYTE_W  = 8;
  localparam int MARK_LSB = 16;
  localparam int MARK_W  = 3;
  localparam int EN_TXWM = 0;
  localparam int EN_RXWM = 1;

  localparam logic [WORD_W-1:0] RX_EMPTY_WORD = 32'h8000_0000;

  typedef enum logic [IDX_W-1:0] {
    IDX_TXD = 3'd0,
    IDX_RXD = 3'd1,
    IDX_TXC = 3'd2,
    IDX_RXC = 3'd3,
    IDX_IEN = 3'd4,
    IDX_IPN = 3'd5,
    IDX_DIV = 3'd6
  } reg_idx_e;

  // Watermark field taken from a control word
  function automatic logic [MARK_W-1:0] mark_of(input logic [WORD_W-1:0] ctl);
    return ctl[MARK_LSB +: MARK_W];
  endfunction

  // Pending bits: transmit mark nonzero, receive level above receive mark
  function automatic logic [1:0] pending_bits(input logic [MARK_W-1:0] tx_mark,
                                              input logic [MARK_W-1:0] rx_mark,
                                              input int unsigned rx_level);
    logic [1:0] p;
    p[EN_TXWM] = (tx_mark != '0);
    p[EN_RXWM] = (rx_level > int'(rx_mark));
    return p;
  endfunction

  // Interrupt rule: transmit enable alone, or receive enable with data present
  function automatic logic irq_level(input logic [1:0] en, input int unsigned rx_level);
    return en[EN_TXWM] | (en[EN_RXWM] & (rx_level != 0));
  endfunction

  function automatic logic [WORD_W-1:0] rx_word(input logic empty, input logic [BYTE_W-1:0] head);
    return empty ? RX_EMPTY_WORD : {{(WORD_W-BYTE_W){1'b0}}, head};
  endfunction

  function automatic logic [WORD_W-1:0] tx_word(input logic full);
    return {full, {(WORD_W-1){1'b0}}};
  endfunction

  function automatic int unsigned level_after(input int unsigned lvl, input logic in_ok, input logic out_ok);
    return lvl + (in_ok ? 1 : 0) - (out_ok ? 1 : 0);
  endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
`timescale 1ns/1ps
module uart_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [LW-1:0]    level,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push_ok) begin
      mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      unique case ({push_ok, pop_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/uart_irq_ctl.sv
`timescale 1ns/1ps
module uart_irq_ctl
  import uart_regfile_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic [WORD_W-1:0] tx_ctl,
  input  logic [WORD_W-1:0] rx_ctl,
  input  logic [1:0]        en_bits,
  input  logic [LW-1:0]     rx_level,
  output logic [1:0]        pend_bits,
  output logic              irq
);

  always_comb begin
    pend_bits = pending_bits(mark_of(tx_ctl), mark_of(rx_ctl), 32'(rx_level));
    irq       = irq_level(en_bits, 32'(rx_level));
  end

endmodule

// File: rtl/uart_regfile.sv
`timescale 1ns/1ps
module uart_regfile
  import uart_regfile_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  output logic        irq
);

  localparam int TX_LW = $clog2(TX_DEPTH + 1);
  localparam int RX_LW = $clog2(RX_DEPTH + 1);

  // Stored registers
  logic [WORD_W-1:0] tx_ctl_q;
  logic [WORD_W-1:0] rx_ctl_q;
  logic [WORD_W-1:0] ien_q;
  logic [WORD_W-1:0] div_q;
  logic              tx_full_q;

  // Named events
  logic              tx_push_req;
  logic              tx_push_ok;
  logic              tx_pop_ok;
  logic              tx_drop;
  logic              rx_pop_req;
  logic              rx_push_ok;
  logic              rx_pop_ok;
  logic              rx_drop;

  logic [BYTE_W-1:0] tx_head;
  logic [TX_LW-1:0]  tx_level;
  logic              tx_full;
  logic              tx_empty;
  logic [BYTE_W-1:0] rx_head;
  logic [RX_LW-1:0]  rx_level;
  logic              rx_full;
  logic              rx_empty;

  logic [1:0]        pend_bits;
  logic [WORD_W-1:0] rd_word;

  assign tx_push_req = reg_wr && (reg_idx == IDX_TXD);
  assign rx_pop_req  = reg_rd && (reg_idx == IDX_RXD);
  assign tx_drop     = tx_push_req && !tx_push_ok;
  assign rx_drop     = rx_valid && !rx_push_ok;

  uart_byte_fifo #(.DEPTH(TX_DEPTH), .WIDTH(BYTE_W)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (tx_push_req),
    .push_data (reg_wdata[BYTE_W-1:0]),
    .pop       (tx_ready),
    .head      (tx_head),
    .level     (tx_level),
    .full      (tx_full),
    .empty     (tx_empty),
    .push_ok   (tx_push_ok),
    .pop_ok    (tx_pop_ok)
  );

  uart_byte_fifo #(.DEPTH(RX_DEPTH), .WIDTH(BYTE_W)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_valid),
    .push_data (rx_data),
    .pop       (rx_pop_req),
    .head      (rx_head),
    .level     (rx_level),
    .full      (rx_full),
    .empty     (rx_empty),
    .push_ok   (rx_push_ok),
    .pop_ok    (rx_pop_ok)
  );

  assign tx_data  = tx_head;
  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  uart_irq_ctl #(.LW(RX_LW)) u_irq (
    .tx_ctl    (tx_ctl_q),
    .rx_ctl    (rx_ctl_q),
    .en_bits   (ien_q[1:0]),
    .rx_level  (rx_level),
    .pend_bits (pend_bits),
    .irq       (irq)
  );

  // Full flag tracks the queue level after each push/drain event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full_q <= 1'b0;
    end else if (tx_push_ok || tx_pop_ok) begin
      tx_full_q <= (level_after(32'(tx_level), tx_push_ok, tx_pop_ok) == TX_DEPTH);
    end
  end

  // Writable registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ctl_q <= '0;
      rx_ctl_q <= '0;
      ien_q    <= '0;
      div_q    <= '0;
    end else if (reg_wr) begin
      unique case (reg_idx)
        IDX_TXC: tx_ctl_q <= reg_wdata;
        IDX_RXC: rx_ctl_q <= reg_wdata;
        IDX_IEN: ien_q    <= reg_wdata;
        IDX_DIV: div_q    <= reg_wdata;
        default: ;
      endcase
    end
  end

  // Read multiplexer
  always_comb begin
    unique case (reg_idx)
      IDX_TXD: rd_word = tx_word(tx_full_q);
      IDX_RXD: rd_word = rx_word(rx_empty, rx_head);
      IDX_TXC: rd_word = tx_ctl_q;
      IDX_RXC: rd_word = rx_ctl_q;
      IDX_IEN: rd_word = ien_q;
      IDX_IPN: rd_word = {{(WORD_W-2){1'b0}}, pend_bits};
      IDX_DIV: rd_word = div_q;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_word;
    end
  end

endmodule

// File: rtl/uart_regfile_chk.sv
`timescale 1ns/1ps
module uart_regfile_chk
  import uart_regfile_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  localparam int TX_LW = $clog2(TX_DEPTH + 1),
  localparam int RX_LW = $clog2(RX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [2:0]       reg_idx,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [RX_LW-1:0] rx_level,
  input logic             rx_push_ok,
  input logic             rx_pop_ok,
  input logic [TX_LW-1:0] tx_level,
  input logic             tx_push_req,
  input logic             tx_pop_ok,
  input logic             irq
);

  // R6
  rx_full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == RX_LW'(RX_DEPTH)) |-> !rx_ready);

  // R6
  rx_drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !rx_pop_ok) |=> (rx_level == $past(rx_level)));

  // R5
  rx_empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_idx == IDX_RXD && rx_level == '0) |=> (reg_rdata == RX_EMPTY_WORD));

  // R4
  rx_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_idx == IDX_RXD && rx_level != '0 && !rx_push_ok)
      |=> (rx_level == $past(rx_level) - RX_LW'(1)));

  // R3
  tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_req && tx_level == TX_LW'(TX_DEPTH) && !tx_pop_ok)
      |=> (tx_level == TX_LW'(TX_DEPTH)));

  // R9
  irq_tx_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IDX_IEN && reg_wdata[EN_TXWM]) |=> irq);

endmodule

bind uart_regfile uart_regfile_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_idx     (reg_idx),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .rx_level    (rx_level),
  .rx_push_ok  (rx_push_ok),
  .rx_pop_ok   (rx_pop_ok),
  .tx_level    (tx_level),
  .tx_push_req (tx_push_req),
  .tx_pop_ok   (tx_pop_ok),
  .irq         (irq)
);

// File: tb/uart_regfile_test.sv
`timescale 1ns/1ps
module uart_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  uart_regfile uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    reg_rd = 1'b1; reg_idx = idx;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rx_offer(input logic [7:0] b, output logic took);
    rx_valid = 1'b1; rx_data = b; took = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic drain_one(input logic [7:0] exp);
    check("R2", "tx_valid", 32'(tx_valid), 32'd1);
    check("R2", "tx_data order", 32'(tx_data), 32'(exp));
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        took;
    logic [7:0]  txb [8];
    logic [7:0]  rxb [8];

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1", "irq", 32'(irq), 32'd0);
    check("R1", "tx_valid", 32'(tx_valid), 32'd0);
    check("R1", "rx_ready", 32'(rx_ready), 32'd1);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), d);
      check("R1", $sformatf("index %0d", i), d, (i == 1) ? 32'h8000_0000 : 32'h0);
    end

    // R10: readback of stored registers
    for (int k = 0; k < 4; k++) begin
      logic [2:0]  idx;
      logic [31:0] pat;
      idx = (k == 0) ? 3'd2 : (k == 1) ? 3'd3 : (k == 2) ? 3'd4 : 3'd6;
      pat = 32'h1357_9BDF ^ (32'(k + 1) * 32'h1111_1111);
      wr(idx, pat);
      rd(idx, d);
      check("R10", $sformatf("readback index %0d", idx), d, pat);
      wr(idx, 32'h0);
    end
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d);
    check("R10", "pending write ignored", d, 32'h0);
    wr(3'd1, 32'h0000_0055);
    rd(3'd1, d);
    check("R10", "rx write ignored", d, 32'h8000_0000);

    // R7: transmit watermark pending bit
    for (int m = 0; m < 8; m++) begin
      wr(3'd2, (32'(m) << 16) | 32'hF0F0_000F);
      rd(3'd5, d);
      check("R7", $sformatf("txmark %0d", m), d, (m != 0) ? 32'h1 : 32'h0);
    end
    wr(3'd2, 32'h0);

    // R2, R3: transmit queue fill, drop and drain
    for (int i = 0; i < 10; i++) begin
      logic [7:0] b;
      b = 8'(i * 37 + 5);
      if (i < 8) txb[i] = b;
      wr(3'd0, {24'hC3A5E1, b});
      rd(3'd0, d);
      check("R3", $sformatf("full flag after %0d writes", i + 1), d,
            (i >= 7) ? 32'h8000_0000 : 32'h0);
    end
    drain_one(txb[0]);
    rd(3'd0, d);
    check("R3", "full flag after one drain", d, 32'h0);
    for (int i = 1; i < 8; i++) drain_one(txb[i]);
    check("R3", "extra writes dropped", 32'(tx_valid), 32'd0);

    // R8, R9: receive level sweep against every mark and enable
    for (int lvl = 0; lvl <= 8; lvl++) begin
      for (int m = 0; m < 8; m++) begin
        wr(3'd3, 32'(m) << 16);
        rd(3'd5, d);
        check("R8", $sformatf("level %0d mark %0d", lvl, m), d, (lvl > m) ? 32'h2 : 32'h0);
      end
      for (int e = 0; e < 4; e++) begin
        wr(3'd4, 32'(e));
        check("R9", $sformatf("level %0d enable %0d", lvl, e), 32'(irq),
              32'(((e & 1) != 0) || (((e & 2) != 0) && lvl != 0)));
      end
      wr(3'd4, 32'h0);
      check("R6", $sformatf("rx_ready at level %0d", lvl), 32'(rx_ready), (lvl < 8) ? 32'd1 : 32'd0);
      if (lvl < 8) begin
        rxb[lvl] = 8'(lvl * 53 + 11);
        rx_offer(rxb[lvl], took);
      end
    end
    wr(3'd3, 32'h0);

    // R6: bytes offered while full are discarded
    rx_offer(8'hEE, took);
    check("R6", "offer while full", 32'(took), 32'd0);
    rx_offer(8'hDD, took);
    check("R6", "second offer while full", 32'(took), 32'd0);

    // R4: reads return bytes in arrival order
    for (int i = 0; i < 8; i++) begin
      rd(3'd1, d);
      check("R4", $sformatf("rx byte %0d", i), d, {24'h0, rxb[i]});
    end
    // R5: empty read
    rd(3'd1, d);
    check("R5", "empty read", d, 32'h8000_0000);
    rd(3'd1, d);
    check("R5", "second empty read", d, 32'h8000_0000);
    wr(3'd4, 32'h2);
    check("R9", "rx enable with empty queue", 32'(irq), 32'd0);
    wr(3'd4, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule